// File: doc/BRIEF.md
# Accumulator Processor Bus Datapath

This block is the register-and-bus half of a small accumulator machine. It holds a program counter, an instruction register, a memory address register, a memory buffer register and an accumulator, all of the same data width. Three internal buses connect them. The address bus is fed by the PC, the IR or the MBR. The result bus is fed by the accumulator or the ALU. The operand bus carries the MBR into the ALU's second input. The ALU either adds the accumulator to the operand bus or passes the operand bus through.

Every transfer is a separate control input, so an external sequencer (hardwired or microcoded) drives the block one cycle at a time. The three ways the PC can change are mutually exclusive, so they arrive as one 2-bit code. On the memory side, the MAR supplies the address and the MBR supplies write data on an output with its own enable. The MBR captures read data only when the memory reports completion by dropping its wait line. The controller branches on the IR's top bits and on the accumulator's sign, so both are brought out as condition outputs.

Top module: `acc_datapath`

## Requirements
- R1: A synchronous active-high reset clears PC, IR, MAR, MBR and AC to zero, and it overrides any control asserted in the same cycle.
- R2: The address bus carries PC, IR or MBR when that source's enable is high, and it reads as zero when no source is enabled. At the next rising edge it loads IR when `abus_to_ir` is high and MAR (its low ADDR_W bits) when `abus_to_mar` is high.
- R3: `pc_op` encodes the PC update: 2'b00 holds, 2'b01 clears to zero, 2'b10 adds one (wrapping 0xFFFF to 0), and 2'b11 loads the address bus.
- R4: The result bus carries AC when `ac_to_rbus` is high or the ALU output when `alu_to_rbus` is high. At the next edge it loads AC when `rbus_to_ac` is high and MBR when `rbus_to_mbr` is high.
- R5: The operand bus equals MBR when `mbr_to_mbus` is high and zero otherwise. The ALU output is AC plus the operand bus, modulo 2^DATA_W, when `alu_add` is 1, and the operand bus itself when `alu_add` is 0.
- R6: `mem_addr` equals MAR while `mar_to_addr` is high and is zero otherwise.
- R7: While `mbr_to_dbus` is high, `mem_wdata` equals MBR and `mem_wdata_en` is 1. Otherwise both are zero.
- R8: With `dbus_to_mbr` high, MBR loads `mem_rdata` only at an edge where `mem_wait` is 0. With `mem_wait` high, MBR holds its value.
- R9: `mem_req` follows `req_ctl` and `mem_rnw` follows `rnw_ctl` (1 = read, 0 = write) in the same cycle.
- R10: `ir_top` equals IR bits [DATA_W-1 -: OPC_W] and `ac_sign` equals AC bit DATA_W-1.
- R11: A register whose load control is low keeps its value across the edge.
- R12: When a completed memory read (`dbus_to_mbr` high, `mem_wait` 0) and `rbus_to_mbr` are both asserted, MBR takes the memory data. When the read is still waiting, MBR takes the result bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_to_abus | input | 1 | PC drives the address bus |
| ir_to_abus | input | 1 | IR drives the address bus |
| mbr_to_abus | input | 1 | MBR drives the address bus |
| ac_to_rbus | input | 1 | AC drives the result bus |
| alu_to_rbus | input | 1 | ALU output drives the result bus |
| abus_to_ir | input | 1 | IR loads from the address bus |
| abus_to_mar | input | 1 | MAR loads from the address bus |
| pc_op | input | 2 | PC update code: hold / clear / increment / load |
| rbus_to_ac | input | 1 | AC loads from the result bus |
| rbus_to_mbr | input | 1 | MBR loads from the result bus |
| mbr_to_mbus | input | 1 | MBR drives the ALU operand bus |
| alu_add | input | 1 | ALU function: 1 add, 0 pass operand |
| dbus_to_mbr | input | 1 | MBR captures read data when the transfer completes |
| mbr_to_dbus | input | 1 | MBR drives the write data output |
| mar_to_addr | input | 1 | MAR drives the memory address output |
| rnw_ctl | input | 1 | Transfer direction, 1 read, 0 write |
| req_ctl | input | 1 | Memory request strobe |
| mem_wait | input | 1 | Memory busy; 0 marks a completed transfer |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_wdata_en | output | 1 | Write data valid |
| mem_rnw | output | 1 | Direction strobe to memory |
| mem_req | output | 1 | Request strobe to memory |
| ir_top | output | OPC_W | IR opcode bits for branching |
| ac_sign | output | 1 | Accumulator sign bit |

## Verification
The bench builds the block with its defaults: DATA_W and ADDR_W of 16 and OPC_W of 2. These widths let a full fetch, load, add, store and jump sequence run with addresses such as 0x8005. They also make the wrap cases reachable in a few cycles: the PC stepping from 0xFFFF to zero, and AC plus MBR overflowing past 0xFFFF. With equal address and data widths, every bit that passes from the address bus into MAR can be read back on the address output. The two opcode bits show the flag path for both IR values 2'b10 and 2'b11.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_ADDR_W = 16;
    localparam int DEF_OPC_W  = 2;

    // Address bus source slots
    localparam int ABUS_SRC_PC  = 0;
    localparam int ABUS_SRC_IR  = 1;
    localparam int ABUS_SRC_MBR = 2;
    localparam int ABUS_SRCS    = 3;

    // Result bus source slots
    localparam int RBUS_SRC_AC  = 0;
    localparam int RBUS_SRC_ALU = 1;
    localparam int RBUS_SRCS    = 2;

    typedef enum logic [1:0] {
        PC_HOLD  = 2'b00,
        PC_CLEAR = 2'b01,
        PC_STEP  = 2'b10,
        PC_JUMP  = 2'b11
    } pc_op_e;

    typedef enum logic {
        ALU_PASS_B = 1'b0,
        ALU_ADD    = 1'b1
    } alu_fn_e;

    // One-hot strobes produced by the PC 2-to-4 decode (hold is implicit)
    typedef struct packed {
        logic clr;
        logic step;
        logic jump;
    } pc_sel_t;

    function automatic pc_sel_t decode_pc_op(input pc_op_e op);
        pc_sel_t s;
        s      = '0;
        s.clr  = (op == PC_CLEAR);
        s.step = (op == PC_STEP);
        s.jump = (op == PC_JUMP);
        return s;
    endfunction

endpackage

// File: rtl/acc_bus_mux.sv
module acc_bus_mux #(
    parameter int N = 2,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        en,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus
);

    logic [N-1:0][W-1:0] gated;

    generate
        for (genvar i = 0; i < N; i++) begin : g_gate
            assign gated[i] = src[i] & {W{en[i]}};
        end
    endgenerate

    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) begin
            bus = bus | gated[i];
        end
    end

    // R2 / R4: a shared bus never has two drivers in one cycle
    p_single_driver_r2_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(en));

endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

endmodule

// File: rtl/acc_pc_unit.sv
module acc_pc_unit
    import acc_dp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  pc_op_e       op,
    input  logic [W-1:0] abus,
    output logic [W-1:0] pc
);

    pc_sel_t sel;

    assign sel = decode_pc_op(op);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (sel.clr) begin
            pc <= '0;
        end else if (sel.step) begin
            pc <= pc + W'(1);
        end else if (sel.jump) begin
            pc <= abus;
        end
    end

    p_pc_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (op == PC_CLEAR) |=> (pc == '0));

    p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
        (op == PC_STEP) |=> (pc == $past(pc) + W'(1)));

    p_pc_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (op == PC_JUMP) |=> (pc == $past(abus)));

    p_pc_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (op == PC_HOLD) |=> $stable(pc));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_dp_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (fn)
            ALU_ADD:    y = a + b;
            ALU_PASS_B: y = b;
            default:    y = b;
        endcase
    end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_dp_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int OPC_W  = DEF_OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_to_abus,
    input  logic              ir_to_abus,
    input  logic              mbr_to_abus,
    input  logic              ac_to_rbus,
    input  logic              alu_to_rbus,
    input  logic              abus_to_ir,
    input  logic              abus_to_mar,
    input  logic [1:0]        pc_op,
    input  logic              rbus_to_ac,
    input  logic              rbus_to_mbr,
    input  logic              mbr_to_mbus,
    input  logic              alu_add,
    input  logic              dbus_to_mbr,
    input  logic              mbr_to_dbus,
    input  logic              mar_to_addr,
    input  logic              rnw_ctl,
    input  logic              req_ctl,
    input  logic              mem_wait,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_en,
    output logic              mem_rnw,
    output logic              mem_req,
    output logic [OPC_W-1:0]  ir_top,
    output logic              ac_sign
);

    localparam int SIGN_BIT = DATA_W - 1;

    logic [DATA_W-1:0] pc_q, ir_q, mbr_q, ac_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] abus, rbus, mbus, alu_y;
    logic [DATA_W-1:0] mbr_d;
    logic              mbr_mem_take, mbr_load;

    logic [ABUS_SRCS-1:0]             abus_en;
    logic [ABUS_SRCS-1:0][DATA_W-1:0] abus_src;
    logic [RBUS_SRCS-1:0]             rbus_en;
    logic [RBUS_SRCS-1:0][DATA_W-1:0] rbus_src;

    // ---------------- address bus ----------------
    always_comb begin
        abus_en                = '0;
        abus_en[ABUS_SRC_PC]   = pc_to_abus;
        abus_en[ABUS_SRC_IR]   = ir_to_abus;
        abus_en[ABUS_SRC_MBR]  = mbr_to_abus;
        abus_src               = '0;
        abus_src[ABUS_SRC_PC]  = pc_q;
        abus_src[ABUS_SRC_IR]  = ir_q;
        abus_src[ABUS_SRC_MBR] = mbr_q;
    end

    acc_bus_mux #(.N(ABUS_SRCS), .W(DATA_W)) u_abus (
        .clk (clk),
        .rst (rst),
        .en  (abus_en),
        .src (abus_src),
        .bus (abus)
    );

    // ---------------- operand bus and ALU ----------------
    assign mbus = mbr_to_mbus ? mbr_q : '0;

    acc_alu #(.W(DATA_W)) u_alu (
        .fn (alu_fn_e'(alu_add)),
        .a  (ac_q),
        .b  (mbus),
        .y  (alu_y)
    );

    // ---------------- result bus ----------------
    always_comb begin
        rbus_en                = '0;
        rbus_en[RBUS_SRC_AC]   = ac_to_rbus;
        rbus_en[RBUS_SRC_ALU]  = alu_to_rbus;
        rbus_src               = '0;
        rbus_src[RBUS_SRC_AC]  = ac_q;
        rbus_src[RBUS_SRC_ALU] = alu_y;
    end

    acc_bus_mux #(.N(RBUS_SRCS), .W(DATA_W)) u_rbus (
        .clk (clk),
        .rst (rst),
        .en  (rbus_en),
        .src (rbus_src),
        .bus (rbus)
    );

    // ---------------- registers ----------------
    acc_pc_unit #(.W(DATA_W)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .op   (pc_op_e'(pc_op)),
        .abus (abus),
        .pc   (pc_q)
    );

    acc_reg #(.W(DATA_W)) u_ir (
        .clk  (clk),
        .rst  (rst),
        .load (abus_to_ir),
        .d    (abus),
        .q    (ir_q)
    );

    acc_reg #(.W(ADDR_W)) u_mar (
        .clk  (clk),
        .rst  (rst),
        .load (abus_to_mar),
        .d    (abus[ADDR_W-1:0]),
        .q    (mar_q)
    );

    acc_reg #(.W(DATA_W)) u_ac (
        .clk  (clk),
        .rst  (rst),
        .load (rbus_to_ac),
        .d    (rbus),
        .q    (ac_q)
    );

    // Completed read beats the result bus; a pending read defers to it
    assign mbr_mem_take = dbus_to_mbr & ~mem_wait;
    assign mbr_load     = mbr_mem_take | rbus_to_mbr;
    assign mbr_d        = mbr_mem_take ? mem_rdata : rbus;

    acc_reg #(.W(DATA_W)) u_mbr (
        .clk  (clk),
        .rst  (rst),
        .load (mbr_load),
        .d    (mbr_d),
        .q    (mbr_q)
    );

    // ---------------- memory side and flags ----------------
    assign mem_addr     = mar_to_addr ? mar_q : '0;
    assign mem_wdata    = mbr_to_dbus ? mbr_q : '0;
    assign mem_wdata_en = mbr_to_dbus;
    assign mem_rnw      = rnw_ctl;
    assign mem_req      = req_ctl;
    assign ir_top       = ir_q[SIGN_BIT -: OPC_W];
    assign ac_sign      = ac_q[SIGN_BIT];

    // ---------------- assertions ----------------
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && ir_q == '0 && mar_q == '0 && mbr_q == '0 && ac_q == '0));

    p_mar_from_abus_r2: assert property (@(posedge clk) disable iff (rst)
        abus_to_mar |=> (mar_q == $past(abus[ADDR_W-1:0])));

    p_ac_from_rbus_r4: assert property (@(posedge clk) disable iff (rst)
        rbus_to_ac |=> (ac_q == $past(rbus)));

    p_mbr_wait_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (dbus_to_mbr && mem_wait && !rbus_to_mbr) |=> $stable(mbr_q));

    p_mbr_mem_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (dbus_to_mbr && !mem_wait) |=> (mbr_q == $past(mem_rdata)));

endmodule

// File: tb/acc_datapath_test.sv
module acc_datapath_test;

    // control word bit map used only by this bench
    localparam logic [17:0] C_NONE  = 18'h00000;
    localparam logic [17:0] C_PCA   = 18'h00001;
    localparam logic [17:0] C_IRA   = 18'h00002;
    localparam logic [17:0] C_MBA   = 18'h00004;
    localparam logic [17:0] C_ACR   = 18'h00008;
    localparam logic [17:0] C_ALR   = 18'h00010;
    localparam logic [17:0] C_AIR   = 18'h00020;
    localparam logic [17:0] C_AMAR  = 18'h00040;
    localparam logic [17:0] C_RAC   = 18'h00080;
    localparam logic [17:0] C_RMBR  = 18'h00100;
    localparam logic [17:0] C_MBUS  = 18'h00200;
    localparam logic [17:0] C_ADD   = 18'h00400;
    localparam logic [17:0] C_DMBR  = 18'h00800;
    localparam logic [17:0] C_MBD   = 18'h01000;
    localparam logic [17:0] C_MADR  = 18'h02000;
    localparam logic [17:0] C_RD    = 18'h04000;
    localparam logic [17:0] C_REQ   = 18'h08000;
    localparam logic [17:0] C_PCCLR = 18'h10000;
    localparam logic [17:0] C_PCINC = 18'h20000;
    localparam logic [17:0] C_PCLD  = 18'h30000;

    typedef struct packed {
        logic [17:0] ctl;
        logic [15:0] rdata;
        logic        wt;
        logic [15:0] exp_addr;
        logic [15:0] exp_wdata;
        logic [2:0]  exp_flags;
    } vec_t;

    localparam int NVEC = 17;

    // fetch, operand load, add, store, jump, then PC step/clear
    localparam vec_t PROG [NVEC] = '{
        '{C_PCA|C_AMAR|C_PCINC|C_MADR,   16'h0000, 1'b0, 16'h0000, 16'h0000, 3'b000},
        '{C_MADR|C_REQ|C_RD|C_DMBR,      16'h8005, 1'b1, 16'h0000, 16'h0000, 3'b000},
        '{C_MADR|C_REQ|C_RD|C_DMBR,      16'h8005, 1'b0, 16'h0000, 16'h0000, 3'b000},
        '{C_MBA|C_AIR|C_MBD,             16'h0000, 1'b0, 16'h0000, 16'h8005, 3'b000},
        '{C_IRA|C_AMAR,                  16'h0000, 1'b0, 16'h0000, 16'h0000, 3'b100},
        '{C_MADR|C_REQ|C_RD|C_DMBR,      16'h7FFF, 1'b0, 16'h8005, 16'h0000, 3'b100},
        '{C_MBUS|C_ALR|C_RAC,            16'h0000, 1'b0, 16'h0000, 16'h0000, 3'b100},
        '{C_MADR|C_REQ|C_RD|C_DMBR,      16'h0001, 1'b0, 16'h8005, 16'h0000, 3'b100},
        '{C_MBUS|C_ADD|C_ALR|C_RAC|C_MBD,16'h0000, 1'b0, 16'h0000, 16'h0001, 3'b100},
        '{C_ACR|C_RMBR,                  16'h0000, 1'b0, 16'h0000, 16'h0000, 3'b101},
        '{C_MBD|C_MADR|C_REQ,            16'h0000, 1'b0, 16'h8005, 16'h8000, 3'b101},
        '{C_IRA|C_PCLD,                  16'h0000, 1'b0, 16'h0000, 16'h0000, 3'b101},
        '{C_PCA|C_AMAR|C_PCINC,          16'h0000, 1'b0, 16'h0000, 16'h0000, 3'b101},
        '{C_PCA|C_AMAR|C_MADR,           16'h0000, 1'b0, 16'h8005, 16'h0000, 3'b101},
        '{C_MADR|C_PCCLR,                16'h0000, 1'b0, 16'h8006, 16'h0000, 3'b101},
        '{C_PCA|C_AMAR|C_MADR,           16'h0000, 1'b0, 16'h8006, 16'h0000, 3'b101},
        '{C_MADR,                        16'h0000, 1'b0, 16'h0000, 16'h0000, 3'b101}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] ctl = '0;
    logic [15:0] rdata = '0;
    logic        wt = 1'b0;

    logic [15:0] mem_addr, mem_wdata;
    logic        mem_wdata_en, mem_rnw, mem_req, ac_sign;
    logic [1:0]  ir_top;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    acc_datapath uut (
        .clk          (clk),
        .rst          (rst),
        .pc_to_abus   (ctl[0]),
        .ir_to_abus   (ctl[1]),
        .mbr_to_abus  (ctl[2]),
        .ac_to_rbus   (ctl[3]),
        .alu_to_rbus  (ctl[4]),
        .abus_to_ir   (ctl[5]),
        .abus_to_mar  (ctl[6]),
        .pc_op        (ctl[17:16]),
        .rbus_to_ac   (ctl[7]),
        .rbus_to_mbr  (ctl[8]),
        .mbr_to_mbus  (ctl[9]),
        .alu_add      (ctl[10]),
        .dbus_to_mbr  (ctl[11]),
        .mbr_to_dbus  (ctl[12]),
        .mar_to_addr  (ctl[13]),
        .rnw_ctl      (ctl[14]),
        .req_ctl      (ctl[15]),
        .mem_wait     (wt),
        .mem_rdata    (rdata),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wdata_en (mem_wdata_en),
        .mem_rnw      (mem_rnw),
        .mem_req      (mem_req),
        .ir_top       (ir_top),
        .ac_sign      (ac_sign)
    );

    // drive at the falling edge, settle, leave room to sample before the rise
    task automatic apply(input logic [17:0] c, input logic [15:0] d, input logic w);
        @(negedge clk);
        ctl   = c;
        rdata = d;
        wt    = w;
        #5;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: state after reset, seen through address, write data and flags
        apply(C_MADR|C_MBD, 16'h0, 1'b0);
        chk("R1 reset MAR on mem_addr", mem_addr, 16'h0000);
        chk("R1 reset MBR on mem_wdata", mem_wdata, 16'h0000);
        chk("R1 reset flags", {13'h0, ir_top, ac_sign}, 16'h0000);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(PROG[i].ctl, PROG[i].rdata, PROG[i].wt);
            chk($sformatf("R6 mem_addr step %0d", i), mem_addr, PROG[i].exp_addr);
            chk($sformatf("R7 mem_wdata step %0d", i), mem_wdata, PROG[i].exp_wdata);
            chk($sformatf("R7 mem_wdata_en step %0d", i), {15'h0, mem_wdata_en},
                {15'h0, PROG[i].ctl[12]});
            chk($sformatf("R10 flags step %0d", i), {13'h0, ir_top, ac_sign},
                {13'h0, PROG[i].exp_flags});
            chk($sformatf("R9 req/rnw step %0d", i), {14'h0, mem_req, mem_rnw},
                {14'h0, PROG[i].ctl[15], PROG[i].ctl[14]});
        end

        // R1: reset wins over a PC increment and an AC load in the same cycle
        @(negedge clk);
        rst = 1'b1;
        ctl = C_PCINC|C_ACR|C_RAC;
        @(negedge clk);
        rst = 1'b0;
        ctl = C_NONE;
        apply(C_MADR|C_MBD|C_PCA|C_AMAR, 16'h0, 1'b0);
        chk("R1 reset clears MBR", mem_wdata, 16'h0000);
        chk("R1 reset clears IR and AC flags", {13'h0, ir_top, ac_sign}, 16'h0000);
        apply(C_MADR, 16'h0, 1'b0);
        chk("R1 reset beats PC increment", mem_addr, 16'h0000);

        // R2: IR load, then load from an undriven address bus
        apply(C_DMBR, 16'hC000, 1'b0);
        apply(C_MBA|C_AIR, 16'h0, 1'b0);
        apply(C_NONE, 16'h0, 1'b0);
        chk("R2 IR loaded from MBR via address bus", {13'h0, ir_top, ac_sign}, 16'h0006);
        apply(C_AIR, 16'h0, 1'b0);
        apply(C_NONE, 16'h0, 1'b0);
        chk("R2 idle address bus reads zero", {13'h0, ir_top, ac_sign}, 16'h0000);

        // R12: completed read beats the result bus; pending read defers to it
        apply(C_DMBR|C_RMBR|C_ACR, 16'h1234, 1'b0);
        apply(C_MBD, 16'h0, 1'b0);
        chk("R12 memory data wins MBR", mem_wdata, 16'h1234);
        apply(C_DMBR|C_RMBR|C_ACR, 16'h5555, 1'b1);
        apply(C_MBD, 16'h0, 1'b0);
        chk("R12 result bus wins while waiting", mem_wdata, 16'h0000);

        // R8: MBR holds while the memory is still busy
        apply(C_DMBR, 16'h1234, 1'b0);
        apply(C_DMBR, 16'hFFFF, 1'b1);
        apply(C_MBD, 16'h0, 1'b0);
        chk("R8 MBR holds while mem_wait high", mem_wdata, 16'h1234);

        // R5: add with wrap, then operand bus disabled
        apply(C_DMBR, 16'hFFFF, 1'b0);
        apply(C_MBUS|C_ALR|C_RAC, 16'h0, 1'b0);
        apply(C_NONE, 16'h0, 1'b0);
        chk("R10 AC sign after pass of 0xFFFF", {13'h0, ir_top, ac_sign}, 16'h0001);
        apply(C_DMBR, 16'h0002, 1'b0);
        apply(C_MBUS|C_ADD|C_ALR|C_RAC, 16'h0, 1'b0);
        apply(C_ACR|C_RMBR, 16'h0, 1'b0);
        apply(C_MBD, 16'h0, 1'b0);
        chk("R5 add wraps 0xFFFF+2", mem_wdata, 16'h0001);
        apply(C_ADD|C_ALR|C_RAC, 16'h0, 1'b0);
        apply(C_ACR|C_RMBR, 16'h0, 1'b0);
        apply(C_MBD, 16'h0, 1'b0);
        chk("R5 add with idle operand bus keeps AC", mem_wdata, 16'h0001);
        apply(C_ALR|C_RAC, 16'h0, 1'b0);
        apply(C_ACR|C_RMBR, 16'h0, 1'b0);
        apply(C_MBD, 16'h0, 1'b0);
        chk("R5 pass with idle operand bus gives zero", mem_wdata, 16'h0000);

        // R3: PC loaded with 0xFFFF, then increment wraps to zero
        apply(C_DMBR, 16'hFFFF, 1'b0);
        apply(C_MBA|C_PCLD, 16'h0, 1'b0);
        apply(C_PCA|C_AMAR|C_PCINC, 16'h0, 1'b0);
        apply(C_MADR|C_PCA|C_AMAR, 16'h0, 1'b0);
        chk("R3 PC load from address bus", mem_addr, 16'hFFFF);
        apply(C_MADR, 16'h0, 1'b0);
        chk("R3 PC increment wraps to zero", mem_addr, 16'h0000);

        // R11: MAR keeps its value with no load over several cycles
        apply(C_NONE, 16'h0, 1'b0);
        apply(C_MADR, 16'h0, 1'b0);
        chk("R11 MAR holds without load", mem_addr, 16'h0000);

        finish_run();
    end

endmodule